// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block is the digital half of a programmable feedback divider in a frequency synthesizer loop. An external prescaler divides the high-frequency input by either P or P+1, as selected by a modulus-control line. This block is clocked by the prescaler output. It holds the swallow count A and the main count B, steers the prescaler modulus, and emits one short pulse per divided period toward the phase detector. Over one output period the prescaler runs A cycles at P+1 and B−A cycles at P, so the total division from the high-frequency input is N = P·B + A.

A frame is the B prescaler cycles between two output pulses. The values A and B are sampled only when a frame starts, so a value that changes mid-frame cannot corrupt the frame in progress. A build-time parameter selects the loop variant. The main loop has P = 32 and a 5-bit swallow count. The auxiliary loop has P = 8 and a 3-bit swallow count. The main count is 11 bits wide in both variants. A power-down input holds the counters cleared and keeps both outputs low. Legal operation requires 2 ≤ B and A ≤ B.

Top module: `swallow_div`

## Requirements
- R1: While rst_n is low, mod_ctrl and div_out are both low.
- R2: In the main-loop variant (P = 32), consecutive rising edges of div_out are exactly 32·B + A prescaler-input cycles apart.
- R3: Each frame lasts exactly B prescaler cycles, and div_out is high for exactly one prescaler cycle of it, the first.
- R4: mod_ctrl is high (selecting P+1) for exactly A prescaler cycles in each frame, namely the first A. It changes only on a rising edge of pclk and rises only together with div_out.
- R5: A and B are sampled only on the pclk edge that starts a frame. A change made mid-frame leaves that frame's length at the old value, and the next frame uses the new one.
- R6: From the first pclk edge at which pwr_dn is seen high, mod_ctrl and div_out stay low and no pulse is issued. After pwr_dn is released, frames resume with the length given by the current A and B.
- R7: In the auxiliary-loop variant (AUX_LOOP = 1, P = 8, 3-bit A), the output period is exactly 8·B + A input cycles, and mod_ctrl is high for A prescaler cycles per frame.
- R8: The boundary settings give the same period: A = 0 (mod_ctrl never high, N = P·B), A = B (every cycle at P+1), the minimum B = 2, and the maximum counts (B = 2047 with A = 7 in the auxiliary loop).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Prescaler output clock; all state advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Synchronous power-down; holds the counters cleared and the outputs low |
| swallow_a | input | SW_W | Swallow count A: number of P+1 cycles per frame |
| main_b | input | MAIN_W | Main count B: prescaler cycles per frame |
| mod_ctrl | output | 1 | Modulus select to the prescaler; 1 selects P+1, 0 selects P |
| div_out | output | 1 | Divided-output pulse, one pclk cycle wide, once per frame |

## Verification
The assertions assume that main_b is at least 2 and never below swallow_a. They also assume that the prescaler latches mod_ctrl late in each of its cycles, long after the pclk edge has settled it. The bench keeps every A/B pair inside that range and never drives B < A. Its prescaler model decides whether to add the extra cycle only at count P−1. It changes A, B and power-down half an input cycle away from any pclk edge, and it judges period, frame length and modulus count only on frames that started after the last change.

// File: rtl/swallow_div.sv
module swallow_div #(
  parameter bit AUX_LOOP = 1'b0,
  parameter int MAIN_W   = 11,
  parameter int SW_W     = AUX_LOOP ? 3 : 5
) (
  input  logic              pclk,
  input  logic              rst_n,
  input  logic              pwr_dn,
  input  logic [SW_W-1:0]   swallow_a,
  input  logic [MAIN_W-1:0] main_b,
  output logic              mod_ctrl,
  output logic              div_out
);

  logic [MAIN_W-1:0] mcnt;
  logic [SW_W-1:0]   scnt;
  logic              frame_end;

  assign frame_end = (mcnt == '0);
  assign mod_ctrl  = |scnt;

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      mcnt    <= '0;
      scnt    <= '0;
      div_out <= 1'b0;
    end else if (pwr_dn) begin
      mcnt    <= '0;
      scnt    <= '0;
      div_out <= 1'b0;
    end else if (frame_end) begin
      mcnt    <= main_b - 1'b1;
      scnt    <= swallow_a;
      div_out <= 1'b1;
    end else begin
      mcnt    <= mcnt - 1'b1;
      if (scnt != '0) scnt <= scnt - 1'b1;
      div_out <= 1'b0;
    end
  end

endmodule

module swallow_div_chk #(
  parameter int MAIN_W = 11,
  parameter int SW_W   = 5
) (
  input logic              pclk,
  input logic              rst_n,
  input logic              pwr_dn,
  input logic [SW_W-1:0]   swallow_a,
  input logic [MAIN_W-1:0] main_b,
  input logic              mod_ctrl,
  input logic              div_out
);

  logic [SW_W-1:0]   a_q, fr_a;
  logic [MAIN_W-1:0] b_q, fr_b;
  logic [MAIN_W:0]   gap, mods;
  logic              valid;

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; fr_a <= '0; fr_b <= '0;
      gap <= '0; mods <= '0; valid <= 1'b0;
    end else begin
      a_q <= swallow_a;
      b_q <= main_b;
      if (pwr_dn) begin
        valid <= 1'b0;
      end else if (div_out) begin
        valid <= 1'b1;
        fr_a  <= a_q;
        fr_b  <= b_q;
        gap   <= {{MAIN_W{1'b0}}, 1'b1};
        mods  <= {{MAIN_W{1'b0}}, mod_ctrl};
      end else begin
        gap  <= gap + 1'b1;
        mods <= mods + {{MAIN_W{1'b0}}, mod_ctrl};
      end
    end
  end

  assert_pd_quiet_R6: assert property (@(posedge pclk) disable iff (!rst_n)
    $past(pwr_dn) |-> (!div_out && !mod_ctrl));

  assert_single_pulse_R3: assert property (@(posedge pclk) disable iff (!rst_n)
    (div_out && !pwr_dn) |=> !div_out);

  assert_frame_len_R3: assert property (@(posedge pclk) disable iff (!rst_n)
    (valid && div_out && !pwr_dn) |-> (gap == {1'b0, fr_b}));

  assert_mod_rise_R4: assert property (@(posedge pclk) disable iff (!rst_n)
    $rose(mod_ctrl) |-> div_out);

  assert_swallow_cnt_R4: assert property (@(posedge pclk) disable iff (!rst_n)
    (valid && div_out && !pwr_dn) |-> (mods == {{(MAIN_W+1-SW_W){1'b0}}, fr_a}));

endmodule

bind swallow_div swallow_div_chk #(.MAIN_W(MAIN_W), .SW_W(SW_W)) u_chk (
  .pclk(pclk), .rst_n(rst_n), .pwr_dn(pwr_dn), .swallow_a(swallow_a),
  .main_b(main_b), .mod_ctrl(mod_ctrl), .div_out(div_out)
);

// File: tb/sim_swallow_div.sv
module sim_presc #(parameter int P = 32) (
  input  logic vin,
  input  logic mod,
  input  logic div,
  output logic pclk
);
  int cnt = 0;
  int vt = 0, last = 0;
  int frames = 0, period = 0, periods = 0, mods = 0, width = 0;
  int cur_p = 0, cur_m = 0, cur_w = 0;
  logic divp = 1'b0;

  assign pclk = (cnt == 0);

  always @(posedge vin) begin
    if ((cnt == P-1 && !mod) || cnt >= P) cnt <= 0;
    else cnt <= cnt + 1;
  end

  always @(negedge vin) begin
    vt = vt + 1;
    if (pclk) begin
      if (div && !divp) begin
        frames  = frames + 1;
        period  = vt - last;
        last    = vt;
        periods = cur_p;
        mods    = cur_m;
        width   = cur_w;
        cur_p = 1;
        cur_m = int'(mod);
        cur_w = 1;
      end else begin
        cur_p = cur_p + 1;
        cur_m = cur_m + int'(mod);
        cur_w = cur_w + int'(div);
      end
      divp = div;
    end
  end
endmodule

module sim_swallow_div;
  logic vin = 1'b0;
  logic rst_n = 1'b0;
  logic pd0 = 1'b0, pd1 = 1'b0;
  logic [4:0]  a0 = 5'd5;
  logic [10:0] b0 = 11'd40;
  logic [2:0]  a1 = 3'd3;
  logic [10:0] b1 = 11'd20;
  logic pclk0, pclk1, mod0, mod1, div0, div1;
  int errors = 0, checks = 0, cycles = 0;

  always #10 vin = ~vin;

  swallow_div u0 (.pclk(pclk0), .rst_n(rst_n), .pwr_dn(pd0), .swallow_a(a0),
                  .main_b(b0), .mod_ctrl(mod0), .div_out(div0));
  swallow_div #(.AUX_LOOP(1'b1)) u1 (.pclk(pclk1), .rst_n(rst_n), .pwr_dn(pd1),
                  .swallow_a(a1), .main_b(b1), .mod_ctrl(mod1), .div_out(div1));

  sim_presc #(.P(32)) m0 (.vin(vin), .mod(mod0), .div(div0), .pclk(pclk0));
  sim_presc #(.P(8))  m1 (.vin(vin), .mod(mod1), .div(div1), .pclk(pclk1));

  always @(posedge vin) begin
    cycles <= cycles + 1;
    if (cycles == 190000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge vin); #1;
  endtask

  task automatic wait_fr(input bit aux, input int n);
    int s = aux ? m1.frames : m0.frames;
    while ((aux ? m1.frames : m0.frames) < s + n) step();
  endtask

  task automatic t_reset();
    int hi = 0;
    for (int i = 0; i < 100; i++) begin
      step();
      hi = hi + int'(mod0) + int'(div0) + int'(mod1) + int'(div1);
    end
    chk("R1", "outputs high during reset", hi, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_main(input int a, input int b, input string tag);
    a0 = 5'(a); b0 = 11'(b);
    wait_fr(1'b0, 2);
    chk(tag, "main period", m0.period, 32*b + a);
    chk("R3", "main frame cycles", m0.periods, b);
    chk("R3", "main pulse width", m0.width, 1);
    chk("R4", "main P+1 cycles", m0.mods, a);
  endtask

  task automatic t_aux(input int a, input int b, input string tag);
    a1 = 3'(a); b1 = 11'(b);
    wait_fr(1'b1, 2);
    chk(tag, "aux period", m1.period, 8*b + a);
    chk("R7", "aux P+1 cycles", m1.mods, a);
    chk("R3", "aux pulse width", m1.width, 1);
  endtask

  task automatic t_midchange();
    a0 = 5'd4; b0 = 11'd30;
    wait_fr(1'b0, 2);
    while (m0.cur_p != 15) step();
    a0 = 5'd9; b0 = 11'd50;
    wait_fr(1'b0, 1);
    chk("R5", "frame in progress keeps old length", m0.period, 32*30 + 4);
    wait_fr(1'b0, 1);
    chk("R5", "next frame uses new length", m0.period, 32*50 + 9);
  endtask

  task automatic t_powerdown();
    int hi = 0;
    int f;
    a0 = 5'd6; b0 = 11'd12;
    wait_fr(1'b0, 2);
    pd0 = 1'b1;
    for (int i = 0; i < 3*33 + 5; i++) step();
    f = m0.frames;
    for (int i = 0; i < 600; i++) begin
      step();
      hi = hi + int'(mod0) + int'(div0);
    end
    chk("R6", "outputs high in power-down", hi, 0);
    chk("R6", "pulses in power-down", m0.frames - f, 0);
    pd0 = 1'b0;
    wait_fr(1'b0, 2);
    chk("R6", "period after release", m0.period, 32*12 + 6);
  endtask

  initial begin
    t_reset();
    t_main(5, 40, "R2");
    t_main(0, 20, "R8");
    t_main(17, 17, "R8");
    t_main(1, 2, "R8");
    t_main(31, 100, "R2");
    t_midchange();
    t_powerdown();
    t_aux(3, 20, "R7");
    t_aux(0, 9, "R8");
    t_aux(7, 7, "R8");
    t_aux(2, 2, "R8");
    t_aux(7, 2047, "R8");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule